// File: doc/BRIEF.md
# Block-gap stop and resume transfer sequencer

This block sequences a multi-block data transfer for an SD-style host. Software programs a block count and starts the transfer. The sequencer then issues one start-next-block pulse per block to a data-line engine and waits for that engine's block-done strobe before it issues the next pulse. The command protocol, the CRC and the data lines stay inside the engine. This block sees only the start pulse and the done strobe.

Software can freeze the transfer cleanly between two blocks. It sets the stop-at-gap bit through the register-write port. The block in flight finishes, the sequencer then parks in a halted state, and it raises the sticky transfer-complete flag. The remaining block count is held. There are two ways to restart:

- A continue request, written together with a cleared stop bit. It is taken only once the sequencer has really halted.
- A separate resume-start input, used after a suspend has been accepted.

An abort input drops any transfer at once.

Every register write carries the following fields:

- the stop-at-gap value, which is stored on each write;
- a continue bit;
- a write-one-to-clear bit for the transfer-complete flag;
- a start bit, taken together with the block count.

The stop, continue and remaining-count state can be read back on dedicated outputs.

Top module: `xfer_gap_ctrl`

## Requirements
- R1: After reset the sequencer is idle. busy_o, tc_o, blk_start_o, stop_o and cont_o are 0, and remain_o is 0.
- R2: A write with wr_start_i=1 while idle and with blk_cnt_i nonzero loads remain_o with blk_cnt_i. It raises busy_o, and blk_start_o pulses in the cycle after the write. A start with a count of 0, or a start while busy_o=1, is ignored.
- R3: blk_start_o is a single-cycle pulse. Each blk_done_i accepted in the active state decrements remain_o. If blocks remain and stop_o=0, the next blk_start_o pulse comes in the cycle after the done strobe.
- R4: The done strobe of the last block (remain_o=1) ends the transfer. In the next cycle busy_o is 0, tc_o is 1 and remain_o is 0, and no further blk_start_o is issued.
- R5: If stop_o=1 when a block that is not the last completes, the sequencer halts. No blk_start_o is issued, busy_o stays 1, tc_o is set and remain_o keeps the untransferred count.
- R6: If stop_o=1 while the last block is in flight, the transfer simply completes as in R4. tc_o is set once and is not set again after it is cleared.
- R7: While halted, a write with wr_cont_i=1 and wr_stop_i=0 is accepted. cont_o reads 1 for exactly one cycle. blk_start_o pulses in the cycle after that, and the transfer goes on with the remaining count.
- R8: A continue request is ignored if the same write leaves wr_stop_i=1, or if the sequencer is not halted. In that case cont_o stays 0 and no blk_start_o is issued.
- R9: resume_i while halted restarts the transfer, with blk_start_o in the next cycle. resume_i in any other state has no effect.
- R10: tc_o is sticky and is cleared by a write with wr_tc_clr_i=1. If a set event falls in the same cycle as a clear, the set wins.
- R11: abort_i returns the sequencer to idle in the next cycle. busy_o goes to 0 and remain_o to 0, and tc_o is not set.
- R12: blk_done_i has no effect outside the active state. While halted, remain_o holds and no blk_start_o is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_stop_i | input | 1 | Stop-at-gap value, stored on every write |
| wr_cont_i | input | 1 | Continue request |
| wr_tc_clr_i | input | 1 | Write one to clear transfer complete |
| wr_start_i | input | 1 | Start transfer |
| blk_cnt_i | input | CNT_W | Block count taken with start |
| blk_done_i | input | 1 | Block finished, strobe from the data engine |
| resume_i | input | 1 | Resume-start after an accepted suspend |
| abort_i | input | 1 | Abort the transfer |
| blk_start_o | output | 1 | Start-next-block pulse |
| tc_o | output | 1 | Sticky transfer-complete flag |
| busy_o | output | 1 | Transfer in progress or halted |
| stop_o | output | 1 | Stop-at-gap bit readback |
| cont_o | output | 1 | Continue bit readback (self-clearing) |
| remain_o | output | CNT_W | Blocks still to transfer |

## Verification
The assertions check the following on every cycle:

- the start pulse lasts a single cycle;
- the continue bit self-clears, and is ever set only in the halted state with stop clear;
- a done strobe with stop set ends in a halt with the count held, and the last done strobe ends in completion;
- the halted state holds;
- a tc clear takes effect;
- an abort returns the sequencer to idle.

Only the bench scenarios can show the following:

- the spacing of block starts across whole transfers of several lengths, with stops at different blocks;
- that ignored continue, resume, start and done requests leave the outputs untouched;
- that a last-block stop gives exactly one completion;
- that set wins over clear on the flag.

// File: rtl/xfer_gap_pkg.sv
package xfer_gap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HALTED = 2'd3
  } seq_state_e;
endpackage

// File: rtl/xfer_blk_cnt.sv
module xfer_blk_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (clr_i)  rem_q <= '0;
    else if (load_i) rem_q <= load_val_i;
    else if (dec_i && rem_q != '0) rem_q <= rem_q - ONE;
  end

  assign rem_o  = rem_q;
  assign last_o = (rem_q == ONE);
endmodule

// File: rtl/xfer_gap_regs.sv
module xfer_gap_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_stop_i,
  input  logic wr_cont_i,
  input  logic wr_tc_clr_i,
  input  logic halted_i,
  input  logic abort_i,
  input  logic tc_set_i,
  output logic stop_o,
  output logic cont_o,
  output logic tc_o
);
  logic stop_q, cont_q, tc_q;
  logic cont_take;

  // continue only from a real halt, with stop cleared by now
  assign cont_take = wr_en_i && wr_cont_i && !wr_stop_i && halted_i &&
                     !abort_i && !cont_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      cont_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      if (wr_en_i) stop_q <= wr_stop_i;
      cont_q <= cont_take;
      if (tc_set_i)                    tc_q <= 1'b1;
      else if (wr_en_i && wr_tc_clr_i) tc_q <= 1'b0;
    end
  end

  assign stop_o = stop_q;
  assign cont_o = cont_q;
  assign tc_o   = tc_q;
endmodule

// File: rtl/xfer_gap_fsm.sv
module xfer_gap_fsm
  import xfer_gap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       blk_done_i,
  input  logic       last_i,
  input  logic       stop_i,
  input  logic       cont_i,
  input  logic       resume_i,
  input  logic       abort_i,
  output seq_state_e state_o,
  output logic       load_o,
  output logic       dec_o,
  output logic       clr_o,
  output logic       tc_set_o,
  output logic       blk_start_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load_o   = 1'b0;
    dec_o    = 1'b0;
    tc_set_o = 1'b0;
    clr_o    = abort_i;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_ISSUE;
        end
        ST_ISSUE: state_d = ST_ACTIVE;
        ST_ACTIVE: if (blk_done_i) begin
          dec_o    = 1'b1;
          if (last_i) begin
            tc_set_o = 1'b1;
            state_d  = ST_IDLE;
          end else if (stop_i) begin
            tc_set_o = 1'b1;
            state_d  = ST_HALTED;
          end else begin
            state_d  = ST_ISSUE;
          end
        end
        ST_HALTED: if (cont_i || resume_i) state_d = ST_ISSUE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign blk_start_o = (state_q == ST_ISSUE);
endmodule

// File: rtl/xfer_gap_ctrl.sv
module xfer_gap_ctrl
  import xfer_gap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_stop_i,
  input  logic             wr_cont_i,
  input  logic             wr_tc_clr_i,
  input  logic             wr_start_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             blk_done_i,
  input  logic             resume_i,
  input  logic             abort_i,
  output logic             blk_start_o,
  output logic             tc_o,
  output logic             busy_o,
  output logic             stop_o,
  output logic             cont_o,
  output logic [CNT_W-1:0] remain_o
);
  seq_state_e state;
  logic load, dec, clr, tc_set, last, start_ok;

  assign start_ok = wr_en_i && wr_start_i && (blk_cnt_i != '0);

  xfer_gap_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_ok),
    .blk_done_i  (blk_done_i),
    .last_i      (last),
    .stop_i      (stop_o),
    .cont_i      (cont_o),
    .resume_i    (resume_i),
    .abort_i     (abort_i),
    .state_o     (state),
    .load_o      (load),
    .dec_o       (dec),
    .clr_o       (clr),
    .tc_set_o    (tc_set),
    .blk_start_o (blk_start_o)
  );

  xfer_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (blk_cnt_i),
    .dec_i      (dec),
    .clr_i      (clr),
    .rem_o      (remain_o),
    .last_o     (last)
  );

  xfer_gap_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_stop_i   (wr_stop_i),
    .wr_cont_i   (wr_cont_i),
    .wr_tc_clr_i (wr_tc_clr_i),
    .halted_i    (state == ST_HALTED),
    .abort_i     (abort_i),
    .tc_set_i    (tc_set),
    .stop_o      (stop_o),
    .cont_o      (cont_o),
    .tc_o        (tc_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/xfer_gap_ctrl_chk.sv
module xfer_gap_ctrl_chk
  import xfer_gap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input seq_state_e       state,
  input logic             wr_en_i,
  input logic             wr_tc_clr_i,
  input logic             blk_done_i,
  input logic             resume_i,
  input logic             abort_i,
  input logic             blk_start_o,
  input logic             tc_o,
  input logic             busy_o,
  input logic             stop_o,
  input logic             cont_o,
  input logic [CNT_W-1:0] remain_o
);
  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_o |=> !blk_start_o);

  assert_cont_self_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_o |=> !cont_o);

  assert_cont_only_halted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_o |-> (state == ST_HALTED && !stop_o));

  assert_gap_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ACTIVE && blk_done_i && !abort_i && stop_o && remain_o > CNT_W'(1))
    |=> (state == ST_HALTED && tc_o && busy_o && remain_o == $past(remain_o) - CNT_W'(1)));

  assert_last_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ACTIVE && blk_done_i && !abort_i && remain_o == CNT_W'(1))
    |=> (!busy_o && tc_o && remain_o == '0));

  assert_tc_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_tc_clr_i && !(state == ST_ACTIVE && blk_done_i)) |=> !tc_o);

  assert_abort_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && remain_o == '0));

  assert_halt_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HALTED && !cont_o && !resume_i && !abort_i)
    |=> (state == ST_HALTED && $stable(remain_o) && !blk_start_o));
endmodule

bind xfer_gap_ctrl xfer_gap_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state       (state),
  .wr_en_i     (wr_en_i),
  .wr_tc_clr_i (wr_tc_clr_i),
  .blk_done_i  (blk_done_i),
  .resume_i    (resume_i),
  .abort_i     (abort_i),
  .blk_start_o (blk_start_o),
  .tc_o        (tc_o),
  .busy_o      (busy_o),
  .stop_o      (stop_o),
  .cont_o      (cont_o),
  .remain_o    (remain_o)
);

// File: tb/xfer_gap_ctrl_tb.sv
`timescale 1ns/1ps
module xfer_gap_ctrl_tb;
  localparam int CNT_W = 16;
  localparam int NV = 6;
  // {block count, block index after which stop is set (0 = never)}
  localparam int VEC [NV][2] = '{'{1, 0}, '{3, 0}, '{4, 2}, '{5, 1}, '{2, 2}, '{6, 5}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 0, wr_stop = 0, wr_cont = 0, wr_tc_clr = 0, wr_start = 0;
  logic [CNT_W-1:0] blk_cnt = '0;
  logic blk_done = 0, resume = 0, abort = 0;
  logic blk_start, tc, busy, stop, cont;
  logic [CNT_W-1:0] remain;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  xfer_gap_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_stop_i(wr_stop),
    .wr_cont_i(wr_cont), .wr_tc_clr_i(wr_tc_clr), .wr_start_i(wr_start),
    .blk_cnt_i(blk_cnt), .blk_done_i(blk_done), .resume_i(resume), .abort_i(abort),
    .blk_start_o(blk_start), .tc_o(tc), .busy_o(busy), .stop_o(stop),
    .cont_o(cont), .remain_o(remain)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input bit s, input bit c, input bit t, input bit st, input int n);
    wr_en = 1; wr_stop = s; wr_cont = c; wr_tc_clr = t; wr_start = st;
    blk_cnt = CNT_W'(n);
    tick();
    wr_en = 0; wr_stop = 0; wr_cont = 0; wr_tc_clr = 0; wr_start = 0;
  endtask

  task automatic done_pulse();
    blk_done = 1; tick(); blk_done = 0;
  endtask

  task automatic run_xfer(input int n, input int stop_at);
    wr(0, 0, 0, 1, n);
    check("R2 start pulse", blk_start, 1);
    check("R2 remain load", remain, n);
    check("R2 busy", busy, 1);
    for (int b = 1; b <= n; b++) begin
      tick();
      check("R3 pulse single", blk_start, 0);
      if (b == stop_at) wr(1, 0, 0, 0, 0);
      done_pulse();
      if (b == n) begin
        check("R4 busy low", busy, 0);
        check("R4 tc set", tc, 1);
        check("R4 remain 0", remain, 0);
        check("R4 no start", blk_start, 0);
        wr(0, 0, 1, 0, 0);
        check("R10 tc cleared", tc, 0);
        tick(); tick();
        check("R6 tc single", tc, 0);
        check("R4 no start after", blk_start, 0);
      end else if (b == stop_at) begin
        check("R5 halted no start", blk_start, 0);
        check("R5 busy", busy, 1);
        check("R5 tc", tc, 1);
        check("R5 remain kept", remain, n - b);
        tick(); tick();
        check("R5 still halted", blk_start, 0);
        wr(1, 0, 1, 0, 0);
        check("R10 tc clear at halt", tc, 0);
        wr(0, 1, 0, 0, 0);
        check("R7 cont set", cont, 1);
        check("R7 no start yet", blk_start, 0);
        tick();
        check("R7 cont cleared", cont, 0);
        check("R7 restart pulse", blk_start, 1);
        check("R7 remain", remain, n - b);
      end else begin
        check("R3 next start", blk_start, 1);
        check("R3 remain dec", remain, n - b);
      end
    end
  endtask

  // bring to halted after the first of n blocks
  task automatic to_halt(input int n);
    wr(1, 0, 0, 1, n);
    tick();
    done_pulse();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 busy", busy, 0);
    check("R1 tc", tc, 0);
    check("R1 start", blk_start, 0);
    check("R1 remain", remain, 0);
    rst_ni = 1;
    tick();
    check("R1 stop", stop, 0);
    check("R1 cont", cont, 0);

    for (int v = 0; v < NV; v++) run_xfer(VEC[v][0], VEC[v][1]);

    // R2: zero count ignored
    wr(0, 0, 0, 1, 0);
    check("R2 zero count busy", busy, 0);
    check("R2 zero count start", blk_start, 0);

    // R2: start while busy ignored; R8: cont while active ignored
    wr(0, 0, 0, 1, 3);
    tick();
    wr(0, 1, 0, 1, 9);
    check("R2 busy start ignored", remain, 3);
    check("R8 cont while active", cont, 0);
    check("R8 no start while active", blk_start, 0);
    abort = 1; tick(); abort = 0;
    check("R11 abort busy", busy, 0);
    check("R11 abort remain", remain, 0);
    check("R11 abort no tc", tc, 0);
    tick();
    check("R11 no start after abort", blk_start, 0);

    // R8: cont with stop still set ignored; R12: done in halted ignored
    to_halt(4);
    check("R5 halt remain", remain, 3);
    wr(1, 1, 1, 0, 0);
    check("R8 cont ignored", cont, 0);
    tick();
    check("R8 no start", blk_start, 0);
    done_pulse();
    check("R12 remain hold", remain, 3);
    check("R12 no start", blk_start, 0);

    // R9: resume restarts
    resume = 1; tick(); resume = 0;
    check("R9 resume start", blk_start, 1);
    check("R9 remain", remain, 3);
    tick();
    resume = 1; tick(); resume = 0;
    check("R9 resume active ignored", blk_start, 0);
    check("R9 remain unchanged", remain, 3);
    // R10: set wins over clear (stop still 1 -> halt with clear in same cycle)
    blk_done = 1; wr_en = 1; wr_stop = 1; wr_tc_clr = 1;
    tick();
    blk_done = 0; wr_en = 0; wr_stop = 0; wr_tc_clr = 0;
    check("R10 set wins", tc, 1);
    check("R5 second halt remain", remain, 2);
    abort = 1; tick(); abort = 0;
    wr(0, 0, 1, 0, 0);
    resume = 1; tick(); resume = 0;
    check("R9 resume idle ignored", blk_start, 0);
    check("R9 resume idle busy", busy, 0);
    // R12: done in idle ignored
    done_pulse();
    check("R12 idle done", remain, 0);
    check("R12 idle tc", tc, 0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule